// File: doc/BRIEF.md
# Repeated Byte Copy Sequencer

This block carries out a whole repeated string-move operation in hardware. A single start strobe hands it three architectural values: a source pointer, a destination pointer and an element count. The block then steps through a loop on its own. In each pass it fetches one byte at the source pointer over a byte-wide read port and stores that byte at the destination pointer over a byte-wide write port. It then bumps both pointers up by one and the count down by one. The loop runs until the count is exhausted.

Both memory ports use a request/ready handshake. A request and its address (and, for writes, its data) stay put until the memory answers, so slow memories simply stretch the loop. The working pointer and count registers are always visible on the outputs. When the operation ends, a one-cycle done pulse marks the moment their final values are valid, which lets the surrounding core write them back as architectural state. A count of zero finishes at once without touching memory.

Top module: `strmove_engine`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `rd_req` and `wr_req` are all low.
- R2: A `start` pulse while idle loads `src_in`, `dst_in` and `cnt_in` into the working registers, and `busy` goes high on the next cycle.
- R3: If `cnt_in` is zero at start, no read or write request is ever raised, and `done` is high in the cycle right after the start cycle.
- R4: Each pass first reads the byte at the current source pointer, then writes that same byte at the current destination pointer; the read always comes before the write.
- R5: `rd_req` and `rd_addr` stay unchanged until a cycle with `rd_ready` high. `wr_req`, `wr_addr` and `wr_data` stay unchanged until a cycle with `wr_ready` high.
- R6: The write handshake ends a pass. On the edge where it completes, `src_out` and `dst_out` each rise by one and `cnt_out` falls by one.
- R7: A start with count N makes exactly N read handshakes and exactly N write handshakes. `done` is then high for one cycle with `cnt_out` equal to zero, after which the block is idle.
- R8: When `done` is high, `src_out` and `dst_out` hold the start values plus N. All three register outputs keep those values after `done` until the next accepted start.
- R9: A `start` raised while `busy` is high is ignored and does not change the result of the operation in progress.
- R10: Bytes move one at a time in ascending address order. When the source and destination ranges overlap, memory therefore ends up exactly as a byte-by-byte forward copy would leave it.
- R11: Pointers wrap modulo 2^ADDR_W, and the count arithmetic is done modulo 2^CNT_W.
- R12: `rd_req` and `wr_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| src_in | input | ADDR_W | Initial source pointer |
| dst_in | input | ADDR_W | Initial destination pointer |
| cnt_in | input | CNT_W | Number of bytes to move |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ready | input | 1 | Read accepted; `rd_data` valid in this cycle |
| rd_data | input | DATA_W | Byte returned by the read |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Byte to store |
| wr_ready | input | 1 | Write accepted in this cycle |
| src_out | output | ADDR_W | Current source pointer |
| dst_out | output | ADDR_W | Current destination pointer |
| cnt_out | output | CNT_W | Remaining count |
| busy | output | 1 | Operation in progress (including the done cycle) |
| done | output | 1 | One-cycle pulse: final register values are valid |

## Verification
The properties assume the memory side follows the handshake: `rd_data` must be valid in any cycle where `rd_ready` is high while a read is pending. They also assume that `rd_ready` and `wr_ready` are only meaningful while the matching request is high. The stimulus keeps to this with a bench memory model that updates ready and read data on the falling edge. It raises ready only in answer to a live request, sometimes immediately and sometimes after random stall cycles, and it always returns the stored byte at the requested address. Stray start pulses are issued only once an operation is long enough to still be running, so every extra pulse lands while `busy` is high.

// File: rtl/strmove_pkg.sv
package strmove_pkg;

   typedef enum logic [1:0] {
      SM_IDLE  = 2'd0,
      SM_FETCH = 2'd1,
      SM_STORE = 2'd2,
      SM_FIN   = 2'd3
   } sm_state_t;

endpackage

// File: rtl/strmove_regs.sv
module strmove_regs #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] src_in,
   input  logic [ADDR_W-1:0] dst_in,
   input  logic [CNT_W-1:0]  cnt_in,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              last
);
   localparam logic [ADDR_W-1:0] PTR_INC = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  CNT_DEC = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         src_q <= src_in;
         dst_q <= dst_in;
         cnt_q <= cnt_in;
      end else if (step) begin
         src_q <= src_q + PTR_INC;
         dst_q <= dst_q + PTR_INC;
         cnt_q <= cnt_q - CNT_DEC;
      end
   end

   assign last = (cnt_q == CNT_DEC);

endmodule

// File: rtl/strmove_buf.sv
module strmove_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dout <= '0;
      else if (cap) dout <= din;
   end
endmodule

// File: rtl/strmove_fsm.sv
module strmove_fsm
   import strmove_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      zero_in,
   input  logic      last,
   input  logic      rd_ready,
   input  logic      wr_ready,
   output sm_state_t state,
   output logic      load,
   output logic      cap,
   output logic      step
);
   sm_state_t nxt;

   always_comb begin
      nxt  = state;
      load = 1'b0;
      cap  = 1'b0;
      step = 1'b0;
      unique case (state)
         SM_IDLE: if (start) begin
            load = 1'b1;
            nxt  = zero_in ? SM_FIN : SM_FETCH;
         end
         SM_FETCH: if (rd_ready) begin
            cap = 1'b1;
            nxt = SM_STORE;
         end
         SM_STORE: if (wr_ready) begin
            step = 1'b1;
            nxt  = last ? SM_FIN : SM_FETCH;
         end
         SM_FIN: nxt = SM_IDLE;
         default: nxt = SM_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SM_IDLE;
      else        state <= nxt;
   end

endmodule

// File: rtl/strmove_engine.sv
module strmove_engine
   import strmove_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] src_in,
   input  logic [ADDR_W-1:0] dst_in,
   input  logic [CNT_W-1:0]  cnt_in,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ready,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] src_out,
   output logic [ADDR_W-1:0] dst_out,
   output logic [CNT_W-1:0]  cnt_out,
   output logic              busy,
   output logic              done
);
   generate
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr_w
         $error("strmove_engine: ADDR_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 64) begin : g_bad_cnt_w
         $error("strmove_engine: CNT_W out of range");
      end
      if (DATA_W != 8) begin : g_bad_data_w
         $error("strmove_engine: element width must be one byte");
      end
   endgenerate

   sm_state_t state;
   logic      load, cap, step, last;
   logic      zero_in;

   assign zero_in = (cnt_in == '0);

   strmove_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .zero_in  (zero_in),
      .last     (last),
      .rd_ready (rd_ready),
      .wr_ready (wr_ready),
      .state    (state),
      .load     (load),
      .cap      (cap),
      .step     (step)
   );

   strmove_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (step),
      .src_in (src_in),
      .dst_in (dst_in),
      .cnt_in (cnt_in),
      .src_q  (src_out),
      .dst_q  (dst_out),
      .cnt_q  (cnt_out),
      .last   (last)
   );

   strmove_buf #(.DATA_W(DATA_W)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (cap),
      .din   (rd_data),
      .dout  (wr_data)
   );

   assign rd_req  = (state == SM_FETCH);
   assign wr_req  = (state == SM_STORE);
   assign rd_addr = src_out;
   assign wr_addr = dst_out;
   assign busy    = (state != SM_IDLE);
   assign done    = (state == SM_FIN);

endmodule

// File: rtl/strmove_engine_chk.sv
module strmove_engine_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CNT_W-1:0]  cnt_in,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_ready,
   input logic              wr_req,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] src_out,
   input logic [ADDR_W-1:0] dst_out,
   input logic [CNT_W-1:0]  cnt_out,
   input logic              busy,
   input logic              done
);
   localparam logic [ADDR_W-1:0] A1 = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  C1 = CNT_W'(1);

   // R12
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

   // R5
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_ready |=> rd_req && $stable(rd_addr));

   // R5
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && !wr_ready |=> wr_req && $stable(wr_addr) && $stable(wr_data));

   // R6
   step_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && wr_ready |=> src_out == $past(src_out) + A1
                          && dst_out == $past(dst_out) + A1
                          && cnt_out == $past(cnt_out) - C1);

   // R3
   zero_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && cnt_in == '0 |=> done && !rd_req && !wr_req);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   // R7
   done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cnt_out == '0 && !rd_req && !wr_req);

   // R8
   final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(src_out) && $stable(dst_out) && $stable(cnt_out));

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);

endmodule

bind strmove_engine strmove_engine_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(cnt_in),
   .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
   .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
   .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
   .busy(busy), .done(done)
);

// File: tb/strmove_engine_test.sv
module strmove_engine_test;
   localparam int AW = 10;
   localparam int CW = 10;
   localparam int MSZ = 1 << AW;
   localparam int MASK = MSZ - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] src_in = '0, dst_in = '0;
   logic [CW-1:0] cnt_in = '0;
   logic          rd_req, wr_req, busy, done;
   logic [AW-1:0] rd_addr, wr_addr, src_out, dst_out;
   logic [CW-1:0] cnt_out;
   logic [7:0]    rd_data = '0;
   logic [7:0]    wr_data;
   logic          rd_ready = 1'b0, wr_ready = 1'b0;

   int total = 0, bad = 0;
   logic [7:0] mem   [MSZ];
   logic [7:0] model [MSZ];
   int  rd_cnt, wr_cnt, addr_err, both_err, exp_rd, exp_wr;
   bit  fast_mode = 0;

   always #5 clk = ~clk;

   strmove_engine #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
      .busy(busy), .done(done)
   );

   // memory model: answers only live requests, sometimes with stalls
   always @(negedge clk) begin
      rd_ready = rd_req && (fast_mode || ($urandom_range(0, 2) != 0));
      rd_data  = rd_req ? mem[rd_addr] : 8'hxx;
      wr_ready = wr_req && (fast_mode || ($urandom_range(0, 2) != 0));
   end

   always @(posedge clk) begin
      if (rd_req && wr_req) both_err++;
      if (rd_req && rd_ready) begin
         if (int'(rd_addr) != (exp_rd & MASK)) addr_err++;
         exp_rd++;
         rd_cnt++;
      end
      if (wr_req && wr_ready) begin
         if (int'(wr_addr) != (exp_wr & MASK)) addr_err++;
         mem[wr_addr] = wr_data;
         exp_wr++;
         wr_cnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic run(input int s, input int d, input int c, input bit glitch);
      int cyc;
      int mism;
      int fs, fd, fc;
      for (int i = 0; i < MSZ; i++) model[i] = mem[i];
      for (int i = 0; i < c; i++) model[(d + i) & MASK] = model[(s + i) & MASK];
      rd_cnt = 0; wr_cnt = 0; addr_err = 0; both_err = 0;
      exp_rd = s; exp_wr = d;
      @(negedge clk);
      start = 1'b1; src_in = AW'(s); dst_in = AW'(d); cnt_in = CW'(c);
      @(negedge clk);
      start = 1'b0;
      src_in = AW'($urandom); dst_in = AW'($urandom); cnt_in = CW'($urandom);
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      cyc = 0;
      while (!done && cyc < 20000) begin
         if (glitch && cyc == 3) begin
            start = 1'b1; cnt_in = '0; src_in = AW'(s + 7);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk(done == 1'b1, "R7 done reached", done, 1);
      if (c == 0) chk(cyc == 0, "R3 done next cycle for zero count", cyc, 0);
      if (glitch) chk(rd_cnt == c, "R9 start while busy ignored", rd_cnt, c);
      chk(int'(src_out) == ((s + c) & MASK), "R8 R11 final source", src_out, (s + c) & MASK);
      chk(int'(dst_out) == ((d + c) & MASK), "R8 R11 final destination", dst_out, (d + c) & MASK);
      chk(cnt_out == '0, "R7 final count", cnt_out, 0);
      chk(rd_cnt == c && wr_cnt == c, "R7 handshake count", rd_cnt * 10000 + wr_cnt, c * 10001);
      chk(addr_err == 0, "R4 address order", addr_err, 0);
      chk(both_err == 0, "R12 one port at a time", both_err, 0);
      mism = 0;
      for (int i = 0; i < MSZ; i++) if (mem[i] !== model[i]) mism++;
      chk(mism == 0, "R4 R10 memory contents", mism, 0);
      fs = src_out; fd = dst_out; fc = cnt_out;
      @(negedge clk);
      chk(!done && !busy, "R7 single done pulse", {done, busy}, 0);
      chk(int'(src_out) == fs && int'(dst_out) == fd && int'(cnt_out) == fc,
          "R8 outputs held", src_out, fs);
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < MSZ; i++) mem[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !rd_req && !wr_req, "R1 reset idle",
          {busy, done, rd_req, wr_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !rd_req && !wr_req, "R1 idle after reset", busy, 0);

      run(10, 100, 0, 0);          // R3 zero count
      run(20, 200, 1, 0);          // single byte
      fast_mode = 1;
      run(30, 300, 5, 0);          // no stalls
      fast_mode = 0;
      run(40, 400, 12, 1);         // R9 stray start
      run(50, 51, 10, 0);          // R10 overlap, destination above
      run(61, 60, 10, 0);          // R10 overlap, destination below
      run(1020, 5, 9, 0);          // R11 source wraps
      run(7, 1018, 9, 0);          // R11 destination wraps
      for (int k = 0; k < 12; k++) begin
         fast_mode = k[0];
         run(int'($urandom_range(0, MASK)), int'($urandom_range(0, MASK)),
             int'($urandom_range(0, 40)), 0);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R7 act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule